// File: doc/BRIEF.md
# SCSI Controller Interrupt Aggregator

This block gathers the interrupt status of a SCSI host controller into three sticky status bytes: one for the DMA engine and two for the SCSI bus side. Each status bit is set by a one-cycle event strobe and stays set until software reads that byte. Reading a byte returns its value and clears it in the same access. Each byte has an enable register. The block combines the enabled bits and a software interrupt-on-the-fly flag into one registered, level-sensitive interrupt line. It also provides a three-bit global summary: bit 0 is DMA pending, bit 1 is SCSI pending, and bit 2 is the on-the-fly flag.

The block also tells the script sequencer when to stop. The SCSI conditions fall into two groups. The completion and selection kinds are non-fatal and stop the sequencer only when they are enabled. Every other condition stops it always. A selection timeout never causes an immediate stop. Any DMA event stops the sequencer whatever the DMA enables are. The stop request is a one-cycle pulse. The register decoder and the sequencer are outside the block.

Top module: `scsi_irq_agg`

## Requirements
- R1: After reset all status bytes, enables and the on-the-fly flag are zero, and `irq`, `gstat`, `halt_req` and `rd_data` read zero.
- R2: `gstat[0]` is 1 exactly when the DMA status is nonzero, and `gstat[1]` is 1 exactly when either SCSI status byte is nonzero. The enables have no effect on either bit. Both bits reflect the status from the clock edge that records it.
- R3: From the edge that changes any status, enable or flag, `irq` equals OR(dma & dma_en) | OR(scsi0 & en0) | OR(scsi1 & en1) | flag.
- R4: While a read strobe (`scsi0_rd`, `scsi1_rd` or `dma_rd`) is high, `rd_data` shows that byte's held value. When more than one strobe is high, the priority is scsi0, then scsi1, then dma. At the edge the byte is cleared. An event on the same byte in the same cycle survives the clear.
- R5: In SCSI status 0, bits 6, 5 and 4 (mask 0x70) request a halt only when their enable bit is set. All other bits of that byte always request a halt.
- R6: In SCSI status 1, bits 1 and 0 (mask 0x03) request a halt only when enabled. Bit 2 (selection timeout, 0x04) never requests a halt. All other bits always request a halt.
- R7: Any nonzero `dma_evt` produces `halt_req` on the next cycle, whatever the DMA enable.
- R8: Status bits are sticky: new events are ORed into the held value, and a bit drops only when its byte is read.
- R9: `intf_set` sets the on-the-fly flag (`gstat[2]`) and `intf_clr` clears it. If both are high in the same cycle, set wins. The flag drives `irq` by itself.
- R10: `halt_req` is a one-cycle pulse. It is due only after a cycle that carried a SCSI or DMA event. The SCSI check covers the whole held SCSI status after merging the new events, using the enable values after any write in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dma_evt | input | 8 | DMA status event strobes |
| scsi0_evt | input | 8 | SCSI status 0 event strobes |
| scsi1_evt | input | 8 | SCSI status 1 event strobes |
| dma_rd | input | 1 | Read-and-clear of DMA status |
| scsi0_rd | input | 1 | Read-and-clear of SCSI status 0 |
| scsi1_rd | input | 1 | Read-and-clear of SCSI status 1 |
| rd_data | output | 8 | Value of the byte being read |
| dma_en_wr | input | 1 | Write strobe, DMA enable |
| scsi0_en_wr | input | 1 | Write strobe, SCSI enable 0 |
| scsi1_en_wr | input | 1 | Write strobe, SCSI enable 1 |
| en_wdata | input | 8 | Enable write data |
| intf_set | input | 1 | Set the on-the-fly flag |
| intf_clr | input | 1 | Clear the on-the-fly flag |
| irq | output | 1 | Level interrupt line |
| gstat | output | 3 | {flag, SCSI pending, DMA pending} |
| halt_req | output | 1 | One-cycle halt request to the sequencer |

## Verification
`rd_data` is combinational, so the bench checks it one time step after driving the read strobe, before the clock edge. `irq`, `gstat` and `halt_req` all change at the first rising edge after the stimulus. The bench applies every stimulus at a falling edge and compares these outputs at the next falling edge. It compares them against a bench model that it advances by exactly one update per clock. A mix of directed halt-group cases and seeded random traffic goes through this same one-cycle step.

// File: rtl/sia_pkg.sv
package sia_pkg;
    localparam int STAT_W = 8;
    localparam int NSRC   = 3;
    localparam int SRC_DMA = 0;
    localparam int SRC_S0  = 1;
    localparam int SRC_S1  = 2;

    typedef logic [STAT_W-1:0] stat_t;

    localparam stat_t S0_SOFT  = stat_t'(8'h70);
    localparam stat_t S1_SOFT  = stat_t'(8'h03);
    localparam stat_t S1_NEVER = stat_t'(8'h04);

    typedef struct packed {
        stat_t dma_en;
        stat_t en0;
        stat_t en1;
        logic  intf;
        logic  irq;
        logic  halt;
    } ctl_t;
endpackage

// File: rtl/sia_stat_reg.sv
module sia_stat_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt,
    input  logic         rd_clr,
    output logic [W-1:0] stat_q,
    output logic [W-1:0] stat_d
);
    always_comb begin
        stat_d = (rd_clr ? '0 : stat_q) | evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_d;
    end
endmodule

// File: rtl/sia_halt_eval.sv
module sia_halt_eval #(
    parameter int           W     = 8,
    parameter logic [W-1:0] SOFT0 = 8'h70,
    parameter logic [W-1:0] SOFT1 = 8'h03,
    parameter logic [W-1:0] NEVER1 = 8'h04
) (
    input  logic [W-1:0] dma_evt,
    input  logic [W-1:0] s0_evt,
    input  logic [W-1:0] s1_evt,
    input  logic [W-1:0] s0_nxt,
    input  logic [W-1:0] s1_nxt,
    input  logic [W-1:0] en0,
    input  logic [W-1:0] en1,
    output logic         halt
);
    logic [W-1:0] gate0;
    logic [W-1:0] gate1;
    logic         scsi_hit;

    always_comb begin
        gate0    = en0 | ~SOFT0;
        gate1    = (en1 | ~SOFT1) & ~NEVER1;
        scsi_hit = (|(s0_nxt & gate0)) | (|(s1_nxt & gate1));
        halt     = (|dma_evt) | (((|s0_evt) | (|s1_evt)) & scsi_hit);
    end
endmodule

// File: rtl/scsi_irq_agg.sv
module scsi_irq_agg
    import sia_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] dma_evt,
    input  logic [STAT_W-1:0] scsi0_evt,
    input  logic [STAT_W-1:0] scsi1_evt,
    input  logic              dma_rd,
    input  logic              scsi0_rd,
    input  logic              scsi1_rd,
    output logic [STAT_W-1:0] rd_data,
    input  logic              dma_en_wr,
    input  logic              scsi0_en_wr,
    input  logic              scsi1_en_wr,
    input  logic [STAT_W-1:0] en_wdata,
    input  logic              intf_set,
    input  logic              intf_clr,
    output logic              irq,
    output logic [2:0]        gstat,
    output logic              halt_req
);
    stat_t evt_a [NSRC];
    logic  rd_a  [NSRC];
    stat_t st_q  [NSRC];
    stat_t st_d  [NSRC];

    assign evt_a[SRC_DMA] = dma_evt;
    assign evt_a[SRC_S0]  = scsi0_evt;
    assign evt_a[SRC_S1]  = scsi1_evt;
    assign rd_a[SRC_DMA]  = dma_rd;
    assign rd_a[SRC_S0]   = scsi0_rd;
    assign rd_a[SRC_S1]   = scsi1_rd;

    for (genvar g = 0; g < NSRC; g++) begin : g_stat
        sia_stat_reg #(.W(STAT_W)) u_stat (
            .clk   (clk),
            .rst_n (rst_n),
            .evt   (evt_a[g]),
            .rd_clr(rd_a[g]),
            .stat_q(st_q[g]),
            .stat_d(st_d[g])
        );
    end

    stat_t dma_st, s0_st, s1_st;
    assign dma_st = st_q[SRC_DMA];
    assign s0_st  = st_q[SRC_S0];
    assign s1_st  = st_q[SRC_S1];

    ctl_t  ctl_d, ctl_q;
    stat_t den_n, en0_n, en1_n;
    logic  halt_n;

    assign den_n = dma_en_wr   ? en_wdata : ctl_q.dma_en;
    assign en0_n = scsi0_en_wr ? en_wdata : ctl_q.en0;
    assign en1_n = scsi1_en_wr ? en_wdata : ctl_q.en1;

    sia_halt_eval #(
        .W(STAT_W), .SOFT0(S0_SOFT), .SOFT1(S1_SOFT), .NEVER1(S1_NEVER)
    ) u_halt (
        .dma_evt(dma_evt),
        .s0_evt (scsi0_evt),
        .s1_evt (scsi1_evt),
        .s0_nxt (st_d[SRC_S0]),
        .s1_nxt (st_d[SRC_S1]),
        .en0    (en0_n),
        .en1    (en1_n),
        .halt   (halt_n)
    );

    always_comb begin
        ctl_d        = ctl_q;
        ctl_d.dma_en = den_n;
        ctl_d.en0    = en0_n;
        ctl_d.en1    = en1_n;
        if (intf_set)      ctl_d.intf = 1'b1;
        else if (intf_clr) ctl_d.intf = 1'b0;
        ctl_d.irq  = (|(st_d[SRC_DMA] & den_n)) | (|(st_d[SRC_S0] & en0_n))
                   | (|(st_d[SRC_S1] & en1_n)) | ctl_d.intf;
        ctl_d.halt = halt_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        if (scsi0_rd)      rd_data = s0_st;
        else if (scsi1_rd) rd_data = s1_st;
        else if (dma_rd)   rd_data = dma_st;
        else               rd_data = '0;
    end

    assign irq      = ctl_q.irq;
    assign halt_req = ctl_q.halt;
    assign gstat    = {ctl_q.intf, (|s0_st) | (|s1_st), |dma_st};
endmodule

// File: rtl/sia_checker.sv
module sia_checker
    import sia_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input stat_t       dma_evt,
    input stat_t       scsi0_evt,
    input stat_t       scsi1_evt,
    input logic        scsi0_rd,
    input logic        intf_set,
    input logic        intf_clr,
    input logic        irq,
    input logic [2:0]  gstat,
    input logic        halt_req,
    input stat_t       s0_st,
    input stat_t       s1_st
);
    AST_DMA_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_evt != '0) |=> gstat[0]); // R2
    AST_SCSI_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        ((scsi0_evt != '0) || (scsi1_evt != '0)) |=> gstat[1]); // R2
    AST_FLAG_DRIVES_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        gstat[2] |-> irq); // R3
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (scsi0_rd && scsi0_evt == '0) |=> (s0_st == '0)); // R4
    AST_STO_NO_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_evt == '0 && scsi0_evt == '0 && scsi1_evt == S1_NEVER
         && s0_st == '0 && (s1_st & ~S1_NEVER) == '0) |=> !halt_req); // R6
    AST_DMA_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_evt != '0) |=> halt_req); // R7
    AST_STICKY_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        !scsi0_rd |=> ((s0_st & $past(s0_st)) == $past(s0_st))); // R8
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (intf_clr && !intf_set) |=> !gstat[2]); // R9
    AST_HALT_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_evt == '0 && scsi0_evt == '0 && scsi1_evt == '0) |=> !halt_req); // R10
endmodule

bind scsi_irq_agg sia_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .dma_evt  (dma_evt),
    .scsi0_evt(scsi0_evt),
    .scsi1_evt(scsi1_evt),
    .scsi0_rd (scsi0_rd),
    .intf_set (intf_set),
    .intf_clr (intf_clr),
    .irq      (irq),
    .gstat    (gstat),
    .halt_req (halt_req),
    .s0_st    (s0_st),
    .s1_st    (s1_st)
);

// File: tb/tb_scsi_irq_agg.sv
module tb_scsi_irq_agg;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] dma_evt, scsi0_evt, scsi1_evt, en_wdata, rd_data;
    logic       dma_rd, scsi0_rd, scsi1_rd;
    logic       dma_en_wr, scsi0_en_wr, scsi1_en_wr, intf_set, intf_clr;
    logic       irq, halt_req;
    logic [2:0] gstat;

    int total = 0;
    int bad   = 0;

    logic [7:0] m_dma = 0, m_s0 = 0, m_s1 = 0, m_den = 0, m_en0 = 0, m_en1 = 0;
    logic       m_intf = 0;

    always #5 clk = ~clk;

    scsi_irq_agg dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle_in();
        dma_evt = 0; scsi0_evt = 0; scsi1_evt = 0; en_wdata = 0;
        dma_rd = 0; scsi0_rd = 0; scsi1_rd = 0;
        dma_en_wr = 0; scsi0_en_wr = 0; scsi1_en_wr = 0;
        intf_set = 0; intf_clr = 0;
    endtask

    function automatic logic f_halt(input logic [7:0] de, s0e, s1e, n0, n1, e0, e1);
        logic hit;
        hit = (|(n0 & (e0 | ~8'h70))) | (|(n1 & (e1 | ~8'h03) & ~8'h04));
        return (|de) | (((|s0e) | (|s1e)) & hit);
    endfunction

    // inputs are set before the call, at a falling edge
    task automatic step();
        logic [7:0] n_dma, n_s0, n_s1, n_den, n_en0, n_en1, e_rd;
        logic n_intf, e_irq, e_halt;
        #1;
        e_rd = scsi0_rd ? m_s0 : scsi1_rd ? m_s1 : dma_rd ? m_dma : 8'h00;
        chk("R4 read data", rd_data, e_rd);
        n_dma = (dma_rd   ? 8'h00 : m_dma) | dma_evt;
        n_s0  = (scsi0_rd ? 8'h00 : m_s0)  | scsi0_evt;
        n_s1  = (scsi1_rd ? 8'h00 : m_s1)  | scsi1_evt;
        n_den = dma_en_wr   ? en_wdata : m_den;
        n_en0 = scsi0_en_wr ? en_wdata : m_en0;
        n_en1 = scsi1_en_wr ? en_wdata : m_en1;
        n_intf = intf_set ? 1'b1 : intf_clr ? 1'b0 : m_intf;
        e_irq = (|(n_dma & n_den)) | (|(n_s0 & n_en0)) | (|(n_s1 & n_en1)) | n_intf;
        e_halt = f_halt(dma_evt, scsi0_evt, scsi1_evt, n_s0, n_s1, n_en0, n_en1);
        @(posedge clk);
        @(negedge clk);
        chk("R3 irq level", irq, e_irq);
        chk("R2 summary bits", gstat[1:0], {(|n_s0) | (|n_s1), |n_dma});
        chk("R9 flag", gstat[2], n_intf);
        chk("R10 halt", halt_req, e_halt);
        m_dma = n_dma; m_s0 = n_s0; m_s1 = n_s1;
        m_den = n_den; m_en0 = n_en0; m_en1 = n_en1; m_intf = n_intf;
        idle_in();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5ca1ab1e));
        idle_in();
        repeat (3) @(negedge clk);
        chk("R1 irq at reset", irq, 0);
        chk("R1 gstat at reset", gstat, 0);
        chk("R1 halt at reset", halt_req, 0);
        chk("R1 rd_data at reset", rd_data, 0);
        rst_n = 1'b1;
        @(negedge clk);
        scsi0_rd = 1; step();
        chk("R1 status zero after reset", gstat, 0);

        // selection timeout, disabled: no halt
        scsi1_evt = 8'h04; step();
        chk("R6 timeout no halt", halt_req, 0);
        scsi1_rd = 1; step();
        // enabled timeout: interrupt yes, halt no
        scsi1_en_wr = 1; en_wdata = 8'hff; step();
        scsi1_evt = 8'h04; step();
        chk("R6 timeout no halt when enabled", halt_req, 0);
        chk("R3 enabled timeout interrupts", irq, 1);
        scsi1_rd = 1; step();
        chk("R4 cleared line", irq, 0);
        // non-fatal status1 enabled: halt
        scsi1_evt = 8'h01; step();
        chk("R6 enabled soft halts", halt_req, 1);
        scsi1_rd = 1; scsi1_en_wr = 1; en_wdata = 8'h00; step();
        scsi1_evt = 8'h02; step();
        chk("R6 masked soft no halt", halt_req, 0);
        scsi1_rd = 1; step();
        scsi1_evt = 8'h08; step();
        chk("R6 fatal halts", halt_req, 1);
        step();
        chk("R10 halt is a pulse", halt_req, 0);
        scsi1_rd = 1; step();

        // status0 groups
        scsi0_evt = 8'h40; step();
        chk("R5 masked complete no halt", halt_req, 0);
        scsi0_rd = 1; scsi0_en_wr = 1; en_wdata = 8'h20; step();
        scsi0_evt = 8'h20; step();
        chk("R5 enabled selected halts", halt_req, 1);
        scsi0_rd = 1; scsi0_en_wr = 1; en_wdata = 8'h00; step();
        scsi0_evt = 8'h01; step();
        chk("R5 fatal halts", halt_req, 1);
        chk("R2 scsi pending", gstat[1], 1);
        scsi0_rd = 1; step();

        // DMA always halts, mask off
        dma_evt = 8'h10; step();
        chk("R7 dma halt", halt_req, 1);
        chk("R2 dma pending masked", gstat[0], 1);
        chk("R3 masked dma no irq", irq, 0);
        dma_rd = 1; step();
        chk("R4 dma cleared", gstat[0], 0);

        // read-clear with simultaneous event, and sticky merge
        scsi0_evt = 8'h01; step();
        scsi0_evt = 8'h04; step();
        scsi0_rd = 1; scsi0_evt = 8'h02; #1;
        chk("R8 sticky merge", rd_data, 8'h05);
        step();
        scsi0_rd = 1; #1;
        chk("R4 event kept over clear", rd_data, 8'h02);
        step();

        // on-the-fly flag
        intf_set = 1; step();
        chk("R9 flag raises line", irq, 1);
        intf_set = 1; intf_clr = 1; step();
        chk("R9 set wins", gstat[2], 1);
        intf_clr = 1; step();
        chk("R9 clear", irq, 0);

        // seeded random traffic
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(3) == 0) dma_evt   = 8'($urandom);
            if ($urandom_range(3) == 0) scsi0_evt = 8'($urandom);
            if ($urandom_range(3) == 0) scsi1_evt = 8'($urandom);
            case ($urandom_range(7))
                0: dma_rd = 1;
                1: scsi0_rd = 1;
                2: scsi1_rd = 1;
                default: ;
            endcase
            en_wdata = 8'($urandom);
            case ($urandom_range(9))
                0: dma_en_wr = 1;
                1: scsi0_en_wr = 1;
                2: scsi1_en_wr = 1;
                default: ;
            endcase
            intf_set = ($urandom_range(15) == 0);
            intf_clr = ($urandom_range(7) == 0);
            step();
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule